// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front-End

This block holds the clocked control path of a single-port burst SRAM with a 512K-word address space and two byte lanes. On each rising clock edge it samples the address, the three chip enables, the processor and controller address strobes, the advance input and the write controls. From these it decides whether the device is selected, loads a burst address and steps it, and registers per-lane write strobes or a read request for the storage array. The array itself sits outside, in the bench a behavioural model.

A burst keeps the upper address bits fixed. The two lowest bits run in a counter that steps in linear order and wraps from 3 to 0, so one burst covers four words. Any accepted strobe reloads the counter. The drive enable for the data bus follows the asynchronous active-low output-enable input. It is held off on the first read clock after the device leaves the deselected state.

Top module: `sram_burst_ctl`

## Requirements
- R1: An accepted strobe selects the device only when cs1_n=0, cs2=1 and cs3_n=0 at that edge. Any other chip-enable combination deselects it. While deselected, mem_we is 2'b00 and mem_rd and bus_drive are 0.
- R2: The processor strobe ads_proc_n=0 is ignored while cs1_n=1. With the controller strobe and advance inactive, mem_addr and selected keep their values. The controller strobe ads_ctrl_n=0 is accepted whatever cs1_n is.
- R3: After an accepted strobe edge, mem_addr equals the address sampled at that edge, even when the device is deselected.
- R4: While selected and with no strobe accepted, adv_n=0 adds one to mem_addr[1:0], wrapping 3 to 0, while mem_addr[18:2] stays unchanged. While deselected, adv_n has no effect.
- R5: With no strobe accepted and adv_n=1, mem_addr holds its value.
- R6: When gw_n=0 at an edge where the device is selected, mem_we becomes 2'b11 whatever bwe_n and bw_n are.
- R7: With gw_n=1 and bwe_n=0, mem_we[i] is 1 exactly when bw_n[i]=0. With gw_n=1 and bwe_n=1, no lane is written.
- R8: A selected clock with no lane written is a read: mem_rd=1 and mem_we=2'b00. mem_rd and a nonzero mem_we never occur together.
- R9: bus_drive is 1 exactly when mem_rd=1 and oe_n=0, and it follows oe_n without waiting for a clock. The exception is the first clock after a strobe moves the device from deselected to selected, when bus_drive is 0.
- R10: A synchronous active-high rst clears mem_addr to 0, deselects the device, clears mem_we and mem_rd and holds bus_drive at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 19 | Word address sampled on a strobe |
| cs1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip enable 2, active high |
| cs3_n | input | 1 | Chip enable 3, active low |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 2 | Per-lane byte select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| mem_addr | output | 19 | Array address: held upper bits and burst count |
| mem_we | output | 2 | Per-lane write strobes to the array, active high |
| mem_rd | output | 1 | Read request to the array |
| bus_drive | output | 1 | Data bus drive enable, active high |
| selected | output | 1 | Device selected state |

## Verification
The bench steps a burst from an odd start address through the wrap at the top of the 2-bit counter. A counter that carried into bit 2 would move to a new four-word block rather than back to its start. It puts a processor strobe next to a high cs1_n with a different address, where a design that did not gate the strobe would reload and jump away from the burst. It checks the global write with byte selects that ask for one lane or none, where lane-by-lane decoding would leave a lane unwritten. It also checks the first read after a deselect. A design without the mask would drive the bus one clock early, and one that masked every read would never drive it after a strobe.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_SEL  = 1'b1
   } sel_state_t;

   function automatic logic cs_match(input logic c1_n, input logic c2, input logic c3_n);
      return (~c1_n) & c2 & (~c3_n);
   endfunction

   function automatic logic strobe_taken(input logic p_n, input logic c_n, input logic c1_n);
      return ((~p_n) & (~c1_n)) | (~c_n);
   endfunction

endpackage

// File: rtl/sram_sel_unit.sv
module sram_sel_unit
   import sram_ctl_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   input  logic cs_ok,
   output logic sel_q,
   output logic sel_nxt,
   output logic first_q
);
   sel_state_t state_q;

   assign sel_q   = (state_q == ST_SEL);
   assign sel_nxt = strobe ? cs_ok : sel_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         first_q <= 1'b0;
      end else begin
         state_q <= sel_nxt ? ST_SEL : ST_IDLE;
         first_q <= strobe & cs_ok & ~sel_q;
      end
   end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr #(
   parameter int ADDR_W  = 19,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic [HI_W-1:0]    base_q;
   logic [BURST_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         base_q <= addr_in[ADDR_W-1:BURST_W];
         cnt_q  <= addr_in[BURST_W-1:0];
      end else if (step) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign addr_out = {base_q, cnt_q};
endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
   parameter int LANES = 2
) (
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic [LANES-1:0] lane_we
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g] = (~gw_n) | ((~bwe_n) & (~bw_n[g]));
   end
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int BURST_W = 2,
   parameter int LANES   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              ads_proc_n,
   input  logic              ads_ctrl_n,
   input  logic              adv_n,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic              oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LANES-1:0]  mem_we,
   output logic              mem_rd,
   output logic              bus_drive,
   output logic              selected
);
   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("ADDR_W must exceed BURST_W");
   end
   if (BURST_W < 1) begin : g_bad_burst
      $error("BURST_W must be at least 1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic             strobe;
   logic             cs_ok;
   logic             sel_q;
   logic             sel_nxt;
   logic             first_q;
   logic [LANES-1:0] lane_we;
   logic [LANES-1:0] we_q;
   logic             rd_q;

   assign strobe = strobe_taken(ads_proc_n, ads_ctrl_n, cs1_n);
   assign cs_ok  = cs_match(cs1_n, cs2, cs3_n);

   sram_sel_unit u_sel (
      .clk     (clk),
      .rst     (rst),
      .strobe  (strobe),
      .cs_ok   (cs_ok),
      .sel_q   (sel_q),
      .sel_nxt (sel_nxt),
      .first_q (first_q)
   );

   sram_burst_addr #(
      .ADDR_W  (ADDR_W),
      .BURST_W (BURST_W)
   ) u_addr (
      .clk      (clk),
      .rst      (rst),
      .load     (strobe),
      .step     (sel_q & ~adv_n & ~strobe),
      .addr_in  (addr_i),
      .addr_out (mem_addr)
   );

   sram_wr_decode #(
      .LANES (LANES)
   ) u_wr (
      .gw_n    (gw_n),
      .bwe_n   (bwe_n),
      .bw_n    (bw_n),
      .lane_we (lane_we)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         we_q <= '0;
         rd_q <= 1'b0;
      end else begin
         we_q <= sel_nxt ? lane_we : '0;
         rd_q <= sel_nxt & (lane_we == '0);
      end
   end

   assign mem_we    = we_q;
   assign mem_rd    = rd_q;
   assign selected  = sel_q;
   assign bus_drive = rd_q & ~first_q & ~oe_n;
endmodule

// File: rtl/sram_burst_ctl_chk.sv
module sram_burst_ctl_chk #(
   parameter int ADDR_W  = 19,
   parameter int BURST_W = 2,
   parameter int LANES   = 2
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr_i,
   input logic              cs1_n,
   input logic              cs2,
   input logic              cs3_n,
   input logic              ads_proc_n,
   input logic              ads_ctrl_n,
   input logic              adv_n,
   input logic              gw_n,
   input logic              bwe_n,
   input logic [LANES-1:0]  bw_n,
   input logic              oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [LANES-1:0]  mem_we,
   input logic              mem_rd,
   input logic              bus_drive,
   input logic              selected
);
   logic acc;
   logic chip_on;
   assign acc     = ((~ads_proc_n) & (~cs1_n)) | (~ads_ctrl_n);
   assign chip_on = (~cs1_n) & cs2 & (~cs3_n);

   // R1
   desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && !chip_on) |=> (!selected && mem_we == '0 && !mem_rd && !bus_drive));

   // R2
   proc_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!ads_proc_n && cs1_n && ads_ctrl_n && adv_n) |=> ($stable(mem_addr) && $stable(selected)));

   // R3
   addr_load_chk: assert property (@(posedge clk) disable iff (rst)
      acc |=> (mem_addr == $past(addr_i)));

   // R4
   burst_step_chk: assert property (@(posedge clk) disable iff (rst)
      (selected && !adv_n && !acc) |=>
         (mem_addr[ADDR_W-1:BURST_W] == $past(mem_addr[ADDR_W-1:BURST_W]) &&
          mem_addr[BURST_W-1:0] == $past(mem_addr[BURST_W-1:0]) + 1'b1));

   // R6
   global_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && chip_on && !gw_n) |=> (mem_we == '1));

   // R7
   byte_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (selected && !acc && gw_n && !bwe_n) |=> (mem_we == ~$past(bw_n)));

   // R8
   rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
      (selected && !acc && gw_n && bwe_n) |=> (mem_we == '0 && mem_rd));

   // R9
   first_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (acc && chip_on && !selected) |=> !bus_drive);

   // R10
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!selected && mem_we == '0 && !mem_rd && !bus_drive && mem_addr == '0));
endmodule

bind sram_burst_ctl sram_burst_ctl_chk #(
   .ADDR_W  (ADDR_W),
   .BURST_W (BURST_W),
   .LANES   (LANES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .addr_i     (addr_i),
   .cs1_n      (cs1_n),
   .cs2        (cs2),
   .cs3_n      (cs3_n),
   .ads_proc_n (ads_proc_n),
   .ads_ctrl_n (ads_ctrl_n),
   .adv_n      (adv_n),
   .gw_n       (gw_n),
   .bwe_n      (bwe_n),
   .bw_n       (bw_n),
   .oe_n       (oe_n),
   .mem_addr   (mem_addr),
   .mem_we     (mem_we),
   .mem_rd     (mem_rd),
   .bus_drive  (bus_drive),
   .selected   (selected)
);

// File: tb/sim_sram_burst_ctl.sv
`timescale 1ns/1ps
module sim_sram_burst_ctl;
   localparam int AW = 19;
   localparam int VW = 54;
   localparam int NV = 17;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr_i = '0;
   logic          cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
   logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
   logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
   logic [1:0]    bw_n = 2'b11;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_we;
   logic          mem_rd, bus_drive, selected;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #2.5 clk = ~clk;

   sram_burst_ctl u0 (
      .clk(clk), .rst(rst), .addr_i(addr_i), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
      .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .gw_n(gw_n),
      .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_rd(mem_rd), .bus_drive(bus_drive), .selected(selected)
   );

   // behavioural two-lane array driven by the strobes
   logic [15:0] mem [0:63];
   always_ff @(posedge clk) begin
      if (mem_we[0]) mem[mem_addr[5:0]][7:0]  <= 8'hA5;
      if (mem_we[1]) mem[mem_addr[5:0]][15:8] <= 8'h5A;
   end

   function automatic logic [VW-1:0] mk(
      input logic [AW-1:0] a, input logic c1, input logic c2, input logic c3,
      input logic p, input logic c, input logic v, input logic g, input logic e,
      input logic [1:0] b, input logic o, input logic xs, input logic [AW-1:0] xa,
      input logic [1:0] xw, input logic xr, input logic xd);
      return {a, c1, c2, c3, p, c, v, g, e, b, o, xs, xa, xw, xr, xd};
   endfunction

   // stimulus applied before an edge, expected outputs after it
   localparam logic [VW-1:0] VEC [NV] = '{
      mk(19'h00000,1,0,1, 1,1,1, 1,1,2'b11,0, 0,19'h00000,2'b00,0,0),
      mk(19'h12345,0,1,0, 0,1,1, 1,1,2'b11,0, 1,19'h12345,2'b00,1,0),
      mk(19'h00000,1,0,1, 1,1,0, 1,1,2'b11,0, 1,19'h12346,2'b00,1,1),
      mk(19'h00000,1,0,1, 1,1,0, 1,1,2'b11,0, 1,19'h12347,2'b00,1,1),
      mk(19'h00000,1,0,1, 1,1,0, 1,1,2'b11,0, 1,19'h12344,2'b00,1,1),
      mk(19'h00000,1,0,1, 1,1,1, 1,1,2'b11,1, 1,19'h12344,2'b00,1,0),
      mk(19'h7FFFF,1,1,0, 0,1,1, 1,1,2'b11,0, 1,19'h12344,2'b00,1,1),
      mk(19'h00003,0,1,0, 1,0,1, 0,1,2'b11,0, 1,19'h00003,2'b11,0,0),
      mk(19'h00000,1,0,1, 1,1,0, 1,0,2'b10,0, 1,19'h00000,2'b01,0,0),
      mk(19'h00000,1,0,1, 1,1,0, 1,0,2'b01,0, 1,19'h00001,2'b10,0,0),
      mk(19'h00000,1,0,1, 1,1,0, 1,1,2'b00,0, 1,19'h00002,2'b00,1,1),
      mk(19'h00000,1,0,1, 1,1,0, 0,0,2'b10,0, 1,19'h00003,2'b11,0,0),
      mk(19'h40000,0,0,0, 1,0,1, 0,1,2'b11,0, 0,19'h40000,2'b00,0,0),
      mk(19'h00000,1,0,1, 1,1,0, 1,1,2'b11,0, 0,19'h40000,2'b00,0,0),
      mk(19'h00010,0,1,1, 1,0,1, 1,1,2'b11,0, 0,19'h00010,2'b00,0,0),
      mk(19'h55555,0,1,0, 0,1,1, 1,1,2'b11,0, 1,19'h55555,2'b00,1,0),
      mk(19'h00000,1,0,1, 1,1,1, 1,1,2'b11,0, 1,19'h55555,2'b00,1,1)
   };

   function automatic string tag(input int i);
      case (i)
         0: return "R1";
         1: return "R3 R9";
         2, 3: return "R4";
         4: return "R4 wrap";
         5: return "R5 R9";
         6: return "R2";
         7, 11: return "R6";
         8, 9: return "R7";
         10: return "R8 R7";
         12, 14: return "R1";
         13: return "R4 R1";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string rq, input logic [AW+4:0] got, input logic [AW+4:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual sel/addr/we/rd/drv=%h expected=%h", rq, got, exp);
      end
   endtask

   function automatic logic [AW+4:0] outs();
      return {selected, mem_addr, mem_we, mem_rd, bus_drive};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R10: state straight out of reset
      chk("R10", outs(), '0);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         {addr_i, cs1_n, cs2, cs3_n, ads_proc_n, ads_ctrl_n, adv_n, gw_n, bwe_n, bw_n, oe_n}
            = VEC[i][VW-1:AW+5];
         @(negedge clk);
         chk(tag(i), outs(), VEC[i][AW+4:0]);
      end
      // R9: drive enable follows oe_n between edges
      #1 oe_n = 1'b1;
      #0.5 chk("R9 async off", outs(), {1'b1, 19'h55555, 2'b00, 1'b1, 1'b0});
      oe_n = 1'b0;
      #0.5 chk("R9 async on", outs(), {1'b1, 19'h55555, 2'b00, 1'b1, 1'b1});
      // R10: reset in the middle of a selected burst
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R10 mid", outs(), '0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule